// File: doc/BRIEF.md
# Semaphore-Gated Descriptor-Chain DMA Sequencer

A single DMA channel that walks a linked list of command words held in memory. Software first points the next-command address register at the head of the list. It then loads a counting semaphore with the number of commands it wants executed. While the count is non-zero and the channel's clock gate is open, the channel does the following for each command:

- It reads one command word over a simple request/acknowledge memory port.
- It runs a placeholder transfer that lasts one cycle per length unit.
- At completion, it applies the command's flags.

A command may follow its link to the next word, take one off the semaphore, and raise a completion status bit that can drive an interrupt.

Adding to the semaphore while the channel is running extends the walk without a restart, so software can append commands on the fly. Control registers have set and clear alias addresses, so single bits change without a read-modify-write. A soft reset bit returns the command state to its power-up values. Setting the clock gate stops the channel at once. The command that was interrupted is fetched again from the start when the gate reopens.

Register word addresses on `reg_addr`:

| Address | Register | Bits |
|---|---|---|
| 0 | control A | bit 0 gate; bit 1 soft reset, write-only through the set alias |
| 1 | control A set alias | |
| 2 | control A clear alias | |
| 4 | control B | bit 0 completion status; bit 16 interrupt enable |
| 5 | control B set alias | |
| 6 | control B clear alias | |
| 8 | next-command address | |
| 9 | semaphore | a write adds; a read returns the count |

Top module: `desc_chain_dma`

## Requirements
- R1: After reset, the channel reports: gate = 1 (address 0 reads 1), address 4 reads 0, next = 0, semaphore = 0, irq = 0 and busy = 0. The channel issues no memory read while the semaphore is 0 or the gate is 1. When the semaphore is non-zero and the gate is 0, it reads the word at the next-command address.
- R2: A command word has the following fields: [11:0] next address, [27:12] length, bit 28 chain, bit 29 decrement, bit 30 interrupt. After the word is acknowledged, `xfer_active` is high for exactly length cycles. For length 0 it is not high at all.
- R3: When a command completes, the semaphore drops by one only if its decrement bit is 1. Otherwise the semaphore is unchanged.
- R4: At completion of a command with chain = 1, the next-command address takes that command's next field, and the walk continues there. A command with chain = 0 leaves the next-command address unchanged. The channel then stays idle, even with a non-zero semaphore, until the semaphore is written again.
- R5: A write to the semaphore adds the written low 8 bits to the count, including while the channel is busy. The count saturates at 255. An add and a decrement in the same cycle both take effect.
- R6: Setting the gate returns the channel to idle on that clock edge. The in-progress transfer ends and no completion effect is applied. Once the gate is cleared, the channel fetches the word at the unchanged next-command address again.
- R7: Writing a 1 through a set alias sets that bit, and through a clear alias clears it. Zero bits leave the register unchanged. A write to the base address loads the bits directly.
- R8: The completion status (address 4 bit 0) sets when a command with the interrupt bit completes. `irq` is status AND enable (address 4 bit 16). Writing bit 0 through the clear alias removes the status.
- R9: Writing bit 1 through the control-A set alias clears the semaphore, the next-command address and the command state. The gate and control-B bits are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 4 | register word address |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data for reg_addr (combinational) |
| mem_rd | output | 1 | command word read request, held until acknowledged |
| mem_addr | output | 12 | command word address |
| mem_rdata | input | 31 | command word |
| mem_ack | input | 1 | command word valid |
| xfer_active | output | 1 | placeholder transfer in progress |
| chan_busy | output | 1 | channel is fetching, transferring or completing |
| irq | output | 1 | completion interrupt |

## Verification
The bench tries several kinds of chain, each aimed at one behaviour:

- A two-command linked chain run under a semaphore of one, which shows that the count and not the link decides how far the walk goes.
- A mix of decrementing and non-decrementing commands, which separates the count of commands run from the count taken off the semaphore.
- An append while a long transfer is running, which shows that an add extends a live walk.
- A non-chained command under a surplus count, which shows the stall.
- An oversized add, which exercises saturation.
- A gate set during a long transfer, followed by a reopen, which shows that the command is fetched again rather than treated as completed.
- A zero-length command, which shows completion with no transfer cycles.

A behavioural model tracks every output and the semaphore read-back on each clock.

// File: rtl/desc_chain_dma.sv
module desc_chain_dma #(
  parameter int ADDR_W = 12,
  parameter int LEN_W  = 16,
  parameter int SEMA_W = 8,
  parameter int REG_W  = 32,
  parameter int EN_OFS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      reg_wr,
  input  logic [3:0]                reg_addr,
  input  logic [REG_W-1:0]          reg_wdata,
  output logic [REG_W-1:0]          reg_rdata,
  output logic                      mem_rd,
  output logic [ADDR_W-1:0]         mem_addr,
  input  logic [ADDR_W+LEN_W+2:0]   mem_rdata,
  input  logic                      mem_ack,
  output logic                      xfer_active,
  output logic                      chan_busy,
  output logic                      irq
);
  localparam int F_LEN_LO = ADDR_W;
  localparam int F_CHAIN  = ADDR_W + LEN_W;
  localparam int F_DEC    = F_CHAIN + 1;
  localparam int F_IRQ    = F_CHAIN + 2;
  localparam logic [SEMA_W+1:0] SEMA_MAX = {2'b00, {SEMA_W{1'b1}}};

  localparam logic [3:0] A_C0 = 4'd0, A_C0_SET = 4'd1, A_C0_CLR = 4'd2;
  localparam logic [3:0] A_C1 = 4'd4, A_C1_SET = 4'd5, A_C1_CLR = 4'd6;
  localparam logic [3:0] A_NEXT = 4'd8, A_SEMA = 4'd9;
  localparam int B_GATE = 0, B_SRST = 1, B_STAT = 0;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER, S_DONE} st_t;

  st_t               st_q;
  logic              gate_q, en_q, stat_q, stall_q;
  logic [SEMA_W-1:0] sema_q;
  logic [ADDR_W-1:0] next_q, cmd_next_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              cmd_chain_q, cmd_dec_q, cmd_irq_q;

  function automatic logic alias_bit(logic q, logic ld, logic set, logic clr, logic w);
    if (ld)             return w;
    else if (set && w)  return 1'b1;
    else if (clr && w)  return 1'b0;
    return q;
  endfunction

  logic w_c0, w_c0s, w_c0c, w_c1, w_c1s, w_c1c, w_next, w_sema;
  assign w_c0   = reg_wr && reg_addr == A_C0;
  assign w_c0s  = reg_wr && reg_addr == A_C0_SET;
  assign w_c0c  = reg_wr && reg_addr == A_C0_CLR;
  assign w_c1   = reg_wr && reg_addr == A_C1;
  assign w_c1s  = reg_wr && reg_addr == A_C1_SET;
  assign w_c1c  = reg_wr && reg_addr == A_C1_CLR;
  assign w_next = reg_wr && reg_addr == A_NEXT;
  assign w_sema = reg_wr && reg_addr == A_SEMA;

  logic srst, gate_d, en_d, stat_d, done_now, run;
  logic [SEMA_W+1:0] sema_sum;
  logic [SEMA_W-1:0] sema_d;
  logic [ADDR_W-1:0] next_d;
  logic              stall_d;

  assign srst     = w_c0s && reg_wdata[B_SRST];
  assign gate_d   = alias_bit(gate_q, w_c0, w_c0s, w_c0c, reg_wdata[B_GATE]);
  assign en_d     = alias_bit(en_q, w_c1, w_c1s, w_c1c, reg_wdata[EN_OFS]);
  assign done_now = st_q == S_DONE && !gate_d && !srst;
  assign stat_d   = alias_bit(stat_q, w_c1, w_c1s, w_c1c, reg_wdata[B_STAT]) | (done_now && cmd_irq_q);

  assign sema_sum = {2'b00, sema_q}
                  + (w_sema ? {2'b00, reg_wdata[SEMA_W-1:0]} : '0)
                  - {{(SEMA_W+1){1'b0}}, done_now && cmd_dec_q};
  assign sema_d   = srst ? '0 : (sema_sum > SEMA_MAX ? SEMA_MAX[SEMA_W-1:0] : sema_sum[SEMA_W-1:0]);
  assign next_d   = srst ? '0 : w_next ? reg_wdata[ADDR_W-1:0] :
                    (done_now && cmd_chain_q) ? cmd_next_q : next_q;
  assign stall_d  = srst ? 1'b0 : w_sema ? 1'b0 : (done_now && !cmd_chain_q) ? 1'b1 : stall_q;
  assign run      = |sema_q && !gate_q && !stall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= 1'b1;
      en_q    <= 1'b0;
      stat_q  <= 1'b0;
      sema_q  <= '0;
      next_q  <= '0;
      stall_q <= 1'b0;
    end else begin
      gate_q  <= gate_d;
      en_q    <= en_d;
      stat_q  <= stat_d;
      sema_q  <= sema_d;
      next_q  <= next_d;
      stall_q <= stall_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      cnt_q       <= '0;
      cmd_next_q  <= '0;
      cmd_chain_q <= 1'b0;
      cmd_dec_q   <= 1'b0;
      cmd_irq_q   <= 1'b0;
    end else if (srst || gate_d) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE:  if (run) st_q <= S_FETCH;
        S_FETCH: if (mem_ack) begin
          cmd_next_q  <= mem_rdata[ADDR_W-1:0];
          cmd_chain_q <= mem_rdata[F_CHAIN];
          cmd_dec_q   <= mem_rdata[F_DEC];
          cmd_irq_q   <= mem_rdata[F_IRQ];
          cnt_q       <= mem_rdata[F_CHAIN-1:F_LEN_LO];
          st_q        <= (mem_rdata[F_CHAIN-1:F_LEN_LO] == '0) ? S_DONE : S_XFER;
        end
        S_XFER: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == LEN_W'(1)) st_q <= S_DONE;
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  logic [REG_W-1:0] c1_view;
  always_comb begin
    c1_view         = '0;
    c1_view[B_STAT] = stat_q;
    c1_view[EN_OFS] = en_q;
  end

  always_comb begin
    unique case (reg_addr)
      A_C0, A_C0_SET, A_C0_CLR: reg_rdata = {{(REG_W-1){1'b0}}, gate_q};
      A_C1, A_C1_SET, A_C1_CLR: reg_rdata = c1_view;
      A_NEXT:                   reg_rdata = {{(REG_W-ADDR_W){1'b0}}, next_q};
      A_SEMA:                   reg_rdata = {{(REG_W-SEMA_W){1'b0}}, sema_q};
      default:                  reg_rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[REG_W-1:EN_OFS+1];

  assign mem_rd      = st_q == S_FETCH;
  assign mem_addr    = next_q;
  assign xfer_active = st_q == S_XFER;
  assign chan_busy   = st_q != S_IDLE;
  assign irq         = stat_q && en_q;
endmodule

// File: rtl/desc_chain_dma_chk.sv
module desc_chain_dma_chk #(
  parameter int SEMA_W = 8,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        st,
  input logic              gate,
  input logic              gate_next,
  input logic [SEMA_W-1:0] sema,
  input logic [LEN_W-1:0]  cnt,
  input logic              mem_rd,
  input logic              xfer_active,
  input logic              stat,
  input logic              cmd_dec,
  input logic              cmd_irq,
  input logic              sema_wr,
  input logic              srst
);
  AST_GATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> !mem_rd && !xfer_active); // R6
  AST_EMPTY_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && sema == '0) |=> !mem_rd); // R1
  AST_XFER_COUNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active |-> cnt != '0); // R2
  AST_KEEP_NO_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && !cmd_dec && !sema_wr && !srst) |=> sema == $past(sema)); // R3
  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && cmd_dec && !gate_next && !sema_wr && !srst) |=> sema == $past(sema) - 1'b1); // R3
  AST_STATUS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd3 && cmd_irq && !gate_next && !srst) |=> stat); // R8
  AST_ADD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sema_wr && !srst && st != 2'd3) |=> sema >= $past(sema)); // R5
endmodule

bind desc_chain_dma desc_chain_dma_chk #(.SEMA_W(SEMA_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st_q), .gate(gate_q), .gate_next(gate_d),
  .sema(sema_q), .cnt(cnt_q), .mem_rd(mem_rd), .xfer_active(xfer_active),
  .stat(stat_q), .cmd_dec(cmd_dec_q), .cmd_irq(cmd_irq_q),
  .sema_wr(w_sema), .srst(srst)
);

// File: tb/desc_chain_dma_test.sv
module desc_chain_dma_test;
  localparam int CLK_T = 10;

  logic        clk = 0, rst_n = 0;
  logic        reg_wr = 0;
  logic [3:0]  reg_addr = 4'd9;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        mem_rd, mem_ack = 0;
  logic [11:0] mem_addr;
  logic [30:0] mem_rdata = 0;
  logic        xfer_active, chan_busy, irq;

  int total = 0, bad = 0, xfer_cycles = 0;
  logic [30:0] mem [0:63];

  desc_chain_dma uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .xfer_active(xfer_active), .chan_busy(chan_busy), .irq(irq)
  );

  always #(CLK_T/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 0;
    else begin
      mem_ack   <= mem_rd && !mem_ack;
      mem_rdata <= mem[mem_addr[5:0]];
    end
  end

  function automatic logic [30:0] mk(int nxt, int len, bit ch, bit dec, bit iq);
    return {iq, dec, ch, len[15:0], nxt[11:0]};
  endfunction

  // behavioural reference: 0 idle, 1 fetch, 2 transfer, 3 complete
  int ms = 0, msema = 0, mnext = 0, mcnt = 0;
  bit mgate = 1, men = 0, mstat = 0, mstall = 0;
  logic [30:0] mc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; msema = 0; mnext = 0; mcnt = 0; mgate = 1; men = 0; mstat = 0; mstall = 0;
    end else begin
      bit srst, ng, ne, nstat, done, nstall;
      int s, nn;
      srst = reg_wr && reg_addr == 1 && reg_wdata[1];
      ng = mgate; ne = men; nstat = mstat;
      if (reg_wr && reg_addr == 0) ng = reg_wdata[0];
      else if (reg_wr && reg_addr == 1 && reg_wdata[0]) ng = 1;
      else if (reg_wr && reg_addr == 2 && reg_wdata[0]) ng = 0;
      if (reg_wr && reg_addr == 4) begin ne = reg_wdata[16]; nstat = reg_wdata[0]; end
      else if (reg_wr && reg_addr == 5) begin if (reg_wdata[16]) ne = 1; if (reg_wdata[0]) nstat = 1; end
      else if (reg_wr && reg_addr == 6) begin if (reg_wdata[16]) ne = 0; if (reg_wdata[0]) nstat = 0; end
      done = ms == 3 && !ng && !srst;
      if (done && mc[30]) nstat = 1;
      if (srst) begin
        ms = 0; msema = 0; mnext = 0; mstall = 0; mcnt = 0;
      end else begin
        s = msema + ((reg_wr && reg_addr == 9) ? int'(reg_wdata[7:0]) : 0) - ((done && mc[29]) ? 1 : 0);
        if (s > 255) s = 255;
        nn = mnext;
        if (reg_wr && reg_addr == 8) nn = int'(reg_wdata[11:0]);
        else if (done && mc[28]) nn = int'(mc[11:0]);
        nstall = mstall;
        if (reg_wr && reg_addr == 9) nstall = 0;
        else if (done && !mc[28]) nstall = 1;
        if (ng) begin ms = 0; mcnt = 0; end
        else case (ms)
          0: if (msema != 0 && !mgate && !mstall) ms = 1;
          1: if (mem_ack) begin
               mc = mem_rdata; mcnt = int'(mem_rdata[27:12]);
               ms = (mcnt == 0) ? 3 : 2;
             end
          2: begin if (mcnt == 1) ms = 3; mcnt = mcnt - 1; end
          default: ms = 0;
        endcase
        msema = s; mnext = nn; mstall = nstall;
      end
      mgate = ng; men = ne; mstat = nstat;
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (xfer_active) xfer_cycles++;
      chk(mem_rd == (ms == 1), "R1 fetch request", mem_rd, ms == 1);
      if (ms == 1) chk(mem_addr == mnext[11:0], "R4 fetch address", mem_addr, mnext);
      chk(xfer_active == (ms == 2), "R2 transfer window", xfer_active, ms == 2);
      chk(chan_busy == (ms != 0), "R1 busy", chan_busy, ms != 0);
      chk(irq == (mstat && men), "R8 irq", irq, mstat && men);
      if (reg_addr == 9) chk(reg_rdata == msema, "R5 semaphore readback", reg_rdata, msema);
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_addr = 4'd9; reg_wdata = 0;
  endtask

  task automatic rd(logic [3:0] a, int exp, string req);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata == exp, req, reg_rdata, exp);
    @(negedge clk); reg_addr = 4'd9;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 0;
    mem[4]  = mk(8, 5, 1, 1, 1);
    mem[8]  = mk(0, 3, 0, 1, 0);
    mem[12] = mk(13, 2, 1, 0, 0);
    mem[13] = mk(14, 2, 1, 1, 0);
    mem[14] = mk(0, 1, 0, 1, 0);
    mem[20] = mk(21, 20, 1, 1, 0);
    mem[21] = mk(22, 20, 1, 1, 0);
    mem[22] = mk(0, 20, 0, 1, 0);
    mem[30] = mk(0, 40, 0, 1, 0);
    mem[31] = mk(0, 0, 0, 1, 1);
    mem[40] = mk(0, 2, 0, 1, 0);
    idle(3); rst_n = 1; idle(2);

    // R1 reset state
    rd(0, 1, "R1 reset gate");
    rd(4, 0, "R1 reset control B");
    rd(8, 0, "R1 reset next");
    rd(9, 0, "R1 reset semaphore");
    chk(irq == 0 && chan_busy == 0, "R1 reset outputs", {irq, chan_busy}, 0);

    // R1 gate holds off a loaded channel
    wr(8, 4); wr(9, 1); idle(10);
    chk(chan_busy == 0, "R1 gated channel stays idle", chan_busy, 0);
    rd(9, 1, "R1 count kept while gated");

    // R7 clear alias opens gate; R4 chain under a count of one
    wr(2, 1); idle(20);
    rd(0, 0, "R7 clear alias on gate");
    rd(8, 8, "R4 next follows chain field");
    rd(9, 0, "R3 decrement at completion");
    chk(xfer_cycles == 5, "R2 length five", xfer_cycles, 5);
    wr(9, 1); idle(15);
    chk(xfer_cycles == 8, "R2 length three", xfer_cycles, 8);
    rd(8, 8, "R4 unchained leaves next");

    // R8 status and enable
    chk(irq == 0, "R8 masked status", irq, 0);
    wr(5, 32'h0001_0000);
    chk(irq == 1, "R8 enabled status", irq, 1);
    rd(4, 32'h0001_0001, "R7 set alias keeps status");
    wr(6, 1);
    rd(4, 32'h0001_0000, "R8 clear alias drops status");
    chk(irq == 0, "R8 irq after clear", irq, 0);

    // R3 non-decrementing command
    wr(8, 12); wr(9, 2); idle(30);
    rd(9, 0, "R3 three commands for count two");
    rd(8, 14, "R4 chain walk end");

    // R5 append while busy
    wr(8, 20); wr(9, 1); idle(8);
    chk(xfer_active == 1, "R5 busy before append", xfer_active, 1);
    wr(9, 2); idle(90);
    rd(9, 0, "R5 appended commands ran");
    rd(8, 22, "R5 walk reached appended tail");

    // R4 stall after unchained command with surplus count
    wr(8, 40); wr(9, 3); idle(15);
    rd(9, 2, "R4 single command then stall");
    chk(chan_busy == 0, "R4 stalled idle", chan_busy, 0);

    // R5 saturation, R9 soft reset
    wr(1, 1); wr(9, 200); wr(9, 100);
    rd(9, 255, "R5 saturate at 255");
    wr(1, 2);
    rd(9, 0, "R9 semaphore cleared");
    rd(8, 0, "R9 next cleared");
    rd(0, 1, "R9 gate kept");
    rd(4, 32'h0001_0000, "R9 control B kept");

    // R6 abort and refetch
    wr(8, 30); wr(9, 1); wr(0, 0); idle(10);
    chk(xfer_active == 1, "R6 running before gate", xfer_active, 1);
    wr(1, 1);
    chk(xfer_active == 0 && chan_busy == 0, "R6 gate aborts", {xfer_active, chan_busy}, 0);
    rd(9, 1, "R6 no completion on abort");
    xfer_cycles = 0;
    wr(2, 1); idle(60);
    chk(xfer_cycles == 40, "R6 refetched full length", xfer_cycles, 40);
    rd(9, 0, "R6 completed after reopen");

    // R2 zero length
    xfer_cycles = 0;
    wr(8, 31); wr(9, 1); idle(10);
    chk(xfer_cycles == 0, "R2 zero length", xfer_cycles, 0);
    rd(9, 0, "R2 zero length completes");
    chk(irq == 1, "R8 status from zero length", irq, 1);

    idle(5);
    summary();
  end
endmodule